// File: doc/BRIEF.md
# SDRAM Burst-Interrupt and Auto-Precharge Tracker

The tracker observes the command stream that a memory controller registers into a four-bank single-data-rate SDRAM. For every bank it keeps a state (idle, open, reading, writing, waiting to precharge, precharging), together with the counters that move a bank through recovery and precharge on its own. It also keeps one shared burst slot, because only one burst can drive the data pins at any time.

A READ or WRITE that arrives while another burst is still issuing cuts that burst off. If the cut-off burst had auto precharge, its bank starts precharging on its own: a read bank precharges on the interrupting edge, and a write bank waits out the write-recovery time first. Each cycle the block reports which bank owns the data bus and in which direction. It pulses a flag when a write cuts into a read without the required mask lead. It pulses another flag when a command does not fit the current state, and such a command is not executed.

Command encoding on `cmd_op`: 0 no-op, 1 activate, 2 read, 3 write, 4 burst stop, 5 precharge; codes 6 and 7 are illegal.

Top module: `sdr_burst_tracker`

## Requirements
- R1: After synchronous reset every bank reads state code 0 (idle), `bus_valid`, `dqm_miss` and `illegal_cmd` are low; bank b's state code sits in `bank_state[3b+2:3b]`.
- R2: State codes are 0 idle, 1 open, 2 reading, 3 writing, 4 precharge pending, 5 precharging. Activate on an idle bank opens it (code 1). A READ or WRITE shows code 2 or 3 from its own edge. Without auto precharge and without interruption, the bank returns to code 1 exactly BURST_LEN edges after the command.
- R3: Read data belongs to the reading bank (`bus_wr`=0) from CAS_LAT edges after the READ for BURST_LEN cycles. Write data belongs to the writing bank (`bus_wr`=1) from the WRITE's own edge for BURST_LEN cycles.
- R4: A READ or WRITE registered while an earlier burst still has beats left cuts it off. An interrupting WRITE owns the bus on its own edge, so the cut write's last word is the one before. An interrupting READ takes the bus CAS_LAT edges later, and the old read data keeps the bus until then.
- R5: A burst with auto precharge that runs to completion enters code 4 when its slot ends. It stays there CAS_LAT cycles after a read or T_WR cycles after a write, then shows code 5 for T_RP cycles, then returns to code 0.
- R6: A read burst with auto precharge that is cut off shows code 5 from the interrupting edge for T_RP cycles, then code 0.
- R7: A write burst with auto precharge that is cut off shows code 4 from the interrupting edge for T_WR cycles, then code 5 for T_RP cycles.
- R8: A WRITE that arrives while a read burst holds the slot pulses `dqm_miss` on its edge unless `dqm_in` was high one edge earlier (read without auto precharge) or two edges earlier (read with auto precharge).
- R9: Burst stop is legal only for the bank that holds the slot and only if that burst has no auto precharge. It frees the slot and returns the bank to code 1. Write data stops on that edge, and read data already requested still owns the bus for CAS_LAT-1 further edges.
- R10: An illegal command pulses `illegal_cmd` for one cycle and leaves the bank states unchanged. Illegal commands are: activate on a non-idle bank, READ/WRITE/precharge on an idle-pending/precharging bank or on a bank whose auto-precharge burst is running, burst stop to another bank, and codes 6 or 7.
- R11: At most one bank is ever in code 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_op | input | 3 | Registered command code |
| cmd_bank | input | $clog2(NUM_BANKS) | Target bank of the command |
| cmd_ap | input | 1 | Auto precharge flag for READ/WRITE |
| dqm_in | input | 1 | Data mask level driven by the controller |
| bank_state | output | 3*NUM_BANKS | Per-bank state codes |
| bus_valid | output | 1 | Data bus carries a burst word |
| bus_bank | output | $clog2(NUM_BANKS) | Bank owning the data bus |
| bus_wr | output | 1 | 1 for write data, 0 for read data |
| dqm_miss | output | 1 | Write cut into a read without mask lead |
| illegal_cmd | output | 1 | Rejected command |

## Verification
The collision that matters most is a new burst being accepted on the same edge that the old bank launches its precharge. One bank moves to code 4 or 5 while another takes the slot and, for writes, the bus. The bench provokes this by cutting auto-precharge reads and writes one or two edges into their bursts. It then judges both banks' codes and the bus owner edge by edge against timings derived from CAS_LAT, T_WR and T_RP. Mask-lead violations are judged on the same interrupting edges.

// File: rtl/sdr_trk_pkg.sv
package sdr_trk_pkg;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_BST = 3'd4,
    OP_PRE = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    BK_IDLE  = 3'd0,
    BK_OPEN  = 3'd1,
    BK_READ  = 3'd2,
    BK_WRITE = 3'd3,
    BK_PEND  = 3'd4,
    BK_PRECH = 3'd5
  } bank_st_e;

  // Cycles spent in the pending state before precharge; 0 means precharge at once.
  function automatic int unsigned ap_delay(logic is_wr, logic was_cut,
                                           int unsigned cl, int unsigned twr);
    if (is_wr)   return twr;
    if (was_cut) return 0;
    return cl;
  endfunction

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sdr_bank_fsm.sv
module sdr_bank_fsm
  import sdr_trk_pkg::*;
#(
  parameter int unsigned CAS_LAT = 2,
  parameter int unsigned T_WR    = 2,
  parameter int unsigned T_RP    = 3,
  parameter int unsigned CW      = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     go_act,
  input  logic     go_burst,
  input  logic     burst_wr,
  input  logic     burst_ap,
  input  logic     go_pre,
  input  logic     stop,
  input  logic     nat_end,
  input  logic     cut,
  output bank_st_e st,
  output logic     ap_flag
);

  logic [CW-1:0] cnt, cnt_n;
  bank_st_e      st_n;
  logic          ap_n;
  int unsigned   dly;

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    ap_n  = ap_flag;
    dly   = ap_delay(st == BK_WRITE, cut, CAS_LAT, T_WR);
    case (st)
      BK_PEND:  if (cnt == CW'(1)) begin st_n = BK_PRECH; cnt_n = CW'(T_RP); end
                else cnt_n = cnt - CW'(1);
      BK_PRECH: if (cnt == CW'(1)) st_n = BK_IDLE;
                else cnt_n = cnt - CW'(1);
      default: ;
    endcase
    if (nat_end || cut) begin
      if (!ap_flag)      st_n = BK_OPEN;
      else if (dly == 0) begin st_n = BK_PRECH; cnt_n = CW'(T_RP); end
      else               begin st_n = BK_PEND;  cnt_n = CW'(dly);  end
      ap_n = 1'b0;
    end
    if (stop) begin st_n = BK_OPEN; ap_n = 1'b0; end
    if (go_act) st_n = BK_OPEN;
    if (go_burst) begin
      st_n = burst_wr ? BK_WRITE : BK_READ;
      ap_n = burst_ap;
    end
    if (go_pre) begin st_n = BK_PRECH; cnt_n = CW'(T_RP); ap_n = 1'b0; end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= BK_IDLE;
      cnt     <= '0;
      ap_flag <= 1'b0;
    end else begin
      st      <= st_n;
      cnt     <= cnt_n;
      ap_flag <= ap_n;
    end
  end

  // R5: pending only leads on to precharge, precharge only to idle
  p_pend_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BK_PEND) |=> (st == BK_PEND || st == BK_PRECH));
  p_prech_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BK_PRECH) |=> (st == BK_PRECH || st == BK_IDLE));
  // R6: cut auto-precharge read precharges on the interrupting edge
  p_cut_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cut && st == BK_READ && ap_flag && !go_burst) |=> (st == BK_PRECH));
  // R7: cut auto-precharge write waits for recovery
  p_cut_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cut && st == BK_WRITE && ap_flag && !go_burst) |=> (st == BK_PEND));

endmodule

// File: rtl/sdr_bus_owner.sv
module sdr_bus_owner #(
  parameter int unsigned BURST_LEN = 4,
  parameter int unsigned CAS_LAT   = 2,
  parameter int unsigned BW        = 2,
  parameter int unsigned CW        = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          new_burst,
  input  logic [BW-1:0] nb_bank,
  input  logic          nb_wr,
  input  logic          nb_ap,
  input  logic          clr,
  input  logic          dqm_in,
  output logic          slot_valid,
  output logic [BW-1:0] slot_bank,
  output logic          slot_wr,
  output logic          slot_ap,
  output logic          slot_last,
  output logic          bus_valid,
  output logic [BW-1:0] bus_bank,
  output logic          bus_wr,
  output logic          dqm_miss
);

  logic [CW-1:0] cnt, cnt_n;
  logic          v_n, wr_n, ap_n;
  logic [BW-1:0] bank_n;
  logic          rd_v [CAS_LAT];
  logic [BW-1:0] rd_b [CAS_LAT];
  logic          dqm_d1, dqm_d2;
  logic          lead_ok, miss_n;

  assign slot_last = slot_valid && (cnt == '0);

  always_comb begin
    v_n = slot_valid; bank_n = slot_bank; wr_n = slot_wr; ap_n = slot_ap; cnt_n = cnt;
    if (new_burst) begin
      v_n = 1'b1; bank_n = nb_bank; wr_n = nb_wr; ap_n = nb_ap; cnt_n = CW'(BURST_LEN - 1);
    end else if (clr || slot_last) begin
      v_n = 1'b0;
    end else if (slot_valid) begin
      cnt_n = cnt - CW'(1);
    end
  end

  assign lead_ok = slot_ap ? dqm_d2 : dqm_d1;
  assign miss_n  = new_burst && nb_wr && slot_valid && !slot_wr && !lead_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_valid <= 1'b0; slot_bank <= '0; slot_wr <= 1'b0; slot_ap <= 1'b0; cnt <= '0;
      for (int i = 0; i < CAS_LAT; i++) begin rd_v[i] <= 1'b0; rd_b[i] <= '0; end
      bus_valid <= 1'b0; bus_bank <= '0; bus_wr <= 1'b0;
      dqm_d1 <= 1'b0; dqm_d2 <= 1'b0; dqm_miss <= 1'b0;
    end else begin
      slot_valid <= v_n; slot_bank <= bank_n; slot_wr <= wr_n; slot_ap <= ap_n; cnt <= cnt_n;
      rd_v[0] <= v_n && !wr_n;
      rd_b[0] <= bank_n;
      for (int i = 1; i < CAS_LAT; i++) begin rd_v[i] <= rd_v[i-1]; rd_b[i] <= rd_b[i-1]; end
      if (v_n && wr_n) begin
        bus_valid <= 1'b1; bus_bank <= bank_n; bus_wr <= 1'b1;
      end else begin
        bus_valid <= rd_v[CAS_LAT-1]; bus_bank <= rd_b[CAS_LAT-1]; bus_wr <= 1'b0;
      end
      dqm_d1   <= dqm_in;
      dqm_d2   <= dqm_d1;
      dqm_miss <= miss_n;
    end
  end

  // R3/R4: an accepted write owns the bus on its own edge
  p_write_owns_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (new_burst && nb_wr) |=> (bus_valid && bus_wr && bus_bank == $past(nb_bank)));
  // R9: burst stop frees the slot
  p_stop_frees_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !new_burst) |=> !slot_valid);

endmodule

// File: rtl/sdr_burst_tracker.sv
module sdr_burst_tracker
  import sdr_trk_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BURST_LEN = 4,
  parameter int unsigned CAS_LAT   = 2,
  parameter int unsigned T_WR      = 2,
  parameter int unsigned T_RP      = 3,
  localparam int unsigned BW       = $clog2(NUM_BANKS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2:0]             cmd_op,
  input  logic [BW-1:0]          cmd_bank,
  input  logic                   cmd_ap,
  input  logic                   dqm_in,
  output logic [3*NUM_BANKS-1:0] bank_state,
  output logic                   bus_valid,
  output logic [BW-1:0]          bus_bank,
  output logic                   bus_wr,
  output logic                   dqm_miss,
  output logic                   illegal_cmd
);

  localparam int unsigned CW = $clog2(max4(BURST_LEN, CAS_LAT, T_WR, T_RP) + 1);

  bank_st_e      st_a [NUM_BANKS];
  logic          ap_a [NUM_BANKS];
  logic [NUM_BANKS-1:0] in_burst;
  logic          slot_valid, slot_wr, slot_ap, slot_last;
  logic [BW-1:0] slot_bank;
  bank_st_e      sel_st;
  logic          sel_burst, sel_locked, bank_ok, legal;
  logic          new_burst, clr, slot_hit;
  op_e           op;

  assign op         = op_e'(cmd_op);
  assign bank_ok    = 32'(cmd_bank) < NUM_BANKS;
  assign sel_st     = bank_ok ? st_a[cmd_bank] : BK_IDLE;
  assign sel_burst  = (sel_st == BK_READ) || (sel_st == BK_WRITE);
  assign sel_locked = sel_burst && bank_ok && ap_a[cmd_bank];
  assign slot_hit   = slot_valid && (slot_bank == cmd_bank);

  always_comb begin
    case (op)
      OP_NOP:         legal = 1'b1;
      OP_ACT:         legal = bank_ok && sel_st == BK_IDLE;
      OP_RD, OP_WR:   legal = bank_ok && (sel_st == BK_OPEN || (sel_burst && !sel_locked));
      OP_BST:         legal = bank_ok && slot_hit && !slot_ap;
      OP_PRE:         legal = bank_ok && (sel_st == BK_IDLE || sel_st == BK_OPEN ||
                                          (sel_burst && !sel_locked));
      default:        legal = 1'b0;
    endcase
  end

  assign new_burst = legal && (op == OP_RD || op == OP_WR);
  assign clr       = legal && slot_hit && (op == OP_BST || op == OP_PRE);

  sdr_bus_owner #(
    .BURST_LEN(BURST_LEN), .CAS_LAT(CAS_LAT), .BW(BW), .CW(CW)
  ) u_bus (
    .clk(clk), .rst_n(rst_n),
    .new_burst(new_burst), .nb_bank(cmd_bank), .nb_wr(op == OP_WR), .nb_ap(cmd_ap),
    .clr(clr), .dqm_in(dqm_in),
    .slot_valid(slot_valid), .slot_bank(slot_bank), .slot_wr(slot_wr),
    .slot_ap(slot_ap), .slot_last(slot_last),
    .bus_valid(bus_valid), .bus_bank(bus_bank), .bus_wr(bus_wr), .dqm_miss(dqm_miss)
  );

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    logic hit, own;
    assign hit = legal && (32'(cmd_bank) == i);
    assign own = slot_valid && (32'(slot_bank) == i);

    sdr_bank_fsm #(
      .CAS_LAT(CAS_LAT), .T_WR(T_WR), .T_RP(T_RP), .CW(CW)
    ) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .go_act  (hit && op == OP_ACT),
      .go_burst(hit && (op == OP_RD || op == OP_WR)),
      .burst_wr(op == OP_WR),
      .burst_ap(cmd_ap),
      .go_pre  (hit && op == OP_PRE && st_a[i] != BK_IDLE),
      .stop    (hit && op == OP_BST),
      .nat_end (own && slot_last),
      .cut     (own && new_burst && !slot_last),
      .st(st_a[i]), .ap_flag(ap_a[i])
    );

    assign bank_state[3*i +: 3] = st_a[i];
    assign in_burst[i] = (st_a[i] == BK_READ) || (st_a[i] == BK_WRITE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) illegal_cmd <= 1'b0;
    else        illegal_cmd <= !legal;
  end

  // R11: a single burst slot
  p_one_burst_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(in_burst) <= 1);
  // R10: a rejected activate leaves the addressed bank where it was
  p_illegal_act_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!legal && op == OP_ACT && sel_st == BK_OPEN) |=> (st_a[$past(cmd_bank)] != BK_IDLE));

endmodule

// File: tb/sdr_burst_tracker_bench.sv
module sdr_burst_tracker_bench;

  localparam int NB = 4, BL = 4, CL = 2, TWR = 3, TRP = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [1:0] cmd_bank = 2'd0;
  logic       cmd_ap = 1'b0;
  logic       dqm_in = 1'b0;
  logic [3*NB-1:0] bank_state;
  logic       bus_valid, bus_wr, dqm_miss, illegal_cmd;
  logic [1:0] bus_bank;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  sdr_burst_tracker #(
    .NUM_BANKS(NB), .BURST_LEN(BL), .CAS_LAT(CL), .T_WR(TWR), .T_RP(TRP)
  ) u_sdr_burst_tracker (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_ap(cmd_ap),
    .dqm_in(dqm_in), .bank_state(bank_state), .bus_valid(bus_valid), .bus_bank(bus_bank),
    .bus_wr(bus_wr), .dqm_miss(dqm_miss), .illegal_cmd(illegal_cmd)
  );

  function automatic int st(int b);
    return int'(bank_state[3*b +: 3]);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // owner encoded as valid*100 + wr*10 + bank
  task automatic chk_bus(string req, int v, int w, int b);
    chk(req, bus_valid ? (100 + (bus_wr ? 10 : 0) + int'(bus_bank)) : 0,
        v ? (100 + w * 10 + b) : 0);
  endtask

  task automatic step(int op, int b, logic ap, logic dq);
    @(negedge clk);
    cmd_op = 3'(op); cmd_bank = 2'(b); cmd_ap = ap; dqm_in = dq;
    @(posedge clk);
    #1;
  endtask

  task automatic nop(int n);
    for (int i = 0; i < n; i++) step(0, 0, 1'b0, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd_op = 3'd0; cmd_ap = 1'b0; dqm_in = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #1_600_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    // R1 reset state
    for (int b = 0; b < NB; b++) chk("R1 state", st(b), 0);
    chk("R1 bus", int'(bus_valid), 0);
    chk("R1 flags", int'(dqm_miss) + int'(illegal_cmd), 0);

    // R2/R3 plain read
    step(1, 0, 0, 0);  chk("R2 act", st(0), 1);
    step(2, 0, 0, 0);  chk("R2 reading", st(0), 2); chk_bus("R3 no data yet", 0, 0, 0);
    nop(1);            chk_bus("R3 latency", 0, 0, 0);
    nop(1);            chk_bus("R3 read owner", 1, 0, 0);
    nop(2);            chk("R2 back open", st(0), 1); chk_bus("R3 read beat", 1, 0, 0);
    nop(1);            chk_bus("R3 last read beat", 1, 0, 0);
    nop(1);            chk_bus("R3 read ended", 0, 0, 0);

    // R3 plain write
    do_reset();
    step(1, 3, 0, 0);
    step(3, 3, 0, 0);  chk_bus("R3 write owner", 1, 1, 3); chk("R2 writing", st(3), 3);
    nop(3);            chk_bus("R3 last write beat", 1, 1, 3);
    nop(1);            chk_bus("R3 write ended", 0, 0, 0); chk("R2 write reopen", st(3), 1);

    // R5 auto precharge read, uninterrupted
    do_reset();
    step(1, 1, 0, 0);
    step(2, 1, 1, 0);
    nop(3);            chk("R5 rd still bursting", st(1), 2);
    nop(1);            chk("R5 rd pending", st(1), 4);
    nop(1);            chk("R5 rd pending end", st(1), 4);
    nop(1);            chk("R5 rd precharging", st(1), 5);
    nop(1);            chk("R5 rd precharge end", st(1), 5);
    nop(1);            chk("R5 rd idle", st(1), 0);

    // R5 auto precharge write, uninterrupted
    do_reset();
    step(1, 2, 0, 0);
    step(3, 2, 1, 0);
    nop(4);            chk("R5 wr pending", st(2), 4);
    nop(2);            chk("R5 wr pending end", st(2), 4);
    nop(1);            chk("R5 wr precharging", st(2), 5);
    nop(1);            chk("R5 wr precharge end", st(2), 5);
    nop(1);            chk("R5 wr idle", st(2), 0);

    // R4/R6/R11 auto precharge read cut by a read
    do_reset();
    step(1, 0, 0, 0);
    step(1, 1, 0, 0);
    step(2, 0, 1, 0);
    nop(1);
    step(2, 1, 0, 0);  chk("R6 cut read precharges", st(0), 5); chk("R4 new reader", st(1), 2);
    chk("R11 one burst", int'(st(0) == 2 || st(0) == 3) + int'(st(1) == 2 || st(1) == 3), 1);
    nop(1);            chk_bus("R4 old read data", 1, 0, 0); chk("R6 precharge held", st(0), 5);
    nop(1);            chk_bus("R4 new read data", 1, 0, 1); chk("R6 idle after tRP", st(0), 0);

    // R4/R7 auto precharge write cut by a write
    do_reset();
    step(1, 0, 0, 0);
    step(1, 2, 0, 0);
    step(3, 0, 1, 0);  chk_bus("R4 first writer", 1, 1, 0);
    step(3, 2, 0, 0);  chk_bus("R4 write takes bus at once", 1, 1, 2); chk("R7 pending", st(0), 4);
    nop(2);            chk("R7 pending held", st(0), 4);
    nop(1);            chk("R7 precharging", st(0), 5);
    nop(1);            chk("R7 precharge held", st(0), 5);
    nop(1);            chk("R7 idle", st(0), 0);

    // R8 non-auto-precharge read cut by write
    do_reset();
    step(1, 1, 0, 0);
    step(1, 2, 0, 0);
    step(2, 1, 0, 0);
    step(0, 0, 0, 1);
    step(3, 2, 0, 0);  chk("R8 lead met", int'(dqm_miss), 0); chk_bus("R4 write over read", 1, 1, 2);
    step(2, 1, 0, 0);
    step(0, 0, 0, 0);
    step(3, 2, 0, 0);  chk("R8 lead missing", int'(dqm_miss), 1);
    nop(1);            chk("R8 single pulse", int'(dqm_miss), 0);

    // R8 auto precharge read cut by write needs two cycles lead
    do_reset();
    step(1, 1, 0, 0);
    step(1, 2, 0, 0);
    step(2, 1, 1, 1);
    step(0, 0, 0, 0);
    step(3, 2, 0, 0);  chk("R8 two-cycle lead met", int'(dqm_miss), 0);
    chk("R6 cut by write precharges", st(1), 5);
    do_reset();
    step(1, 1, 0, 0);
    step(1, 2, 0, 0);
    step(2, 1, 1, 0);
    step(0, 0, 0, 1);
    step(3, 2, 0, 0);  chk("R8 one-cycle lead too short", int'(dqm_miss), 1);

    // R10 illegal commands
    do_reset();
    step(2, 0, 0, 0);  chk("R10 read idle bank", int'(illegal_cmd), 1); chk("R10 bank kept", st(0), 0);
    nop(1);            chk("R10 pulse ends", int'(illegal_cmd), 0);
    step(1, 0, 0, 0);
    step(1, 0, 0, 0);  chk("R10 double act", int'(illegal_cmd), 1); chk("R10 still open", st(0), 1);
    step(7, 0, 0, 0);  chk("R10 bad code", int'(illegal_cmd), 1);
    step(2, 0, 1, 0);
    step(2, 0, 0, 0);  chk("R10 ap burst locked", int'(illegal_cmd), 1); chk("R10 still reading", st(0), 2);
    step(4, 1, 0, 0);  chk("R10 stop other bank", int'(illegal_cmd), 1);
    nop(1);
    step(5, 0, 0, 0);  chk("R10 precharge locked", int'(illegal_cmd), 1); chk("R10 pending kept", st(0), 4);

    // R9 burst stop
    do_reset();
    step(1, 0, 0, 0);
    step(3, 0, 0, 0);
    step(4, 0, 0, 0);  chk_bus("R9 write stops", 0, 0, 0); chk("R9 reopened", st(0), 1);
    chk("R9 stop legal", int'(illegal_cmd), 0);
    step(2, 0, 0, 0);
    step(4, 0, 0, 0);
    nop(1);            chk_bus("R9 read tail", 1, 0, 0);
    nop(1);            chk_bus("R9 read stopped", 0, 0, 0);
    step(2, 0, 1, 0);
    step(4, 0, 0, 0);  chk("R9 stop on ap burst", int'(illegal_cmd), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule